// File: doc/BRIEF.md
# Three-Wire Serial Control Word Transmitter

This block is the host end of a three-wire control link (serial clock, serial data, latch strobe) that loads 10-bit control words into a peripheral. A client offers a word on a valid/ready handshake. The block then shifts the word out most significant bit first. The peripheral samples each bit on the rising edge of the serial clock. After the last bit, the block raises the latch strobe to commit the word and returns all three lines low.

Each timing minimum is a parameter in nanoseconds: clock phase width, data setup before the clock rise, data hold after it, latch setup after the last clock, latch width, data hold after the latch, and the low gap before the next word. Each minimum becomes a count of system clock cycles. The conversion rounds up against the system clock frequency parameter, so no interval comes out short. The client sees `busy` for the whole transfer, including the closing gap, and a one-cycle `done` pulse when the latch returns low.

Top module: `serial_word_tx`

## Requirements
- R1: Each accepted word is sent as exactly WORD_W (10) bits, most significant bit first. The value on `ser_data` at the k-th rising edge of `ser_clk` equals bit WORD_W-k of the word.
- R2: Every high phase and every low phase of `ser_clk` between two rising edges lasts at least ceil(T_PHASE_NS x CLK_HZ / 1e9) cycles.
- R3: `ser_data` is stable for at least the setup count (ceil of T_SETUP_NS) before each rising edge of `ser_clk`. It does not change while `ser_clk` is high, which lasts at least the hold count (ceil of T_HOLD_NS).
- R4: `ser_latch` rises only while `ser_clk` is low, at least the latch-setup count after the last fall of `ser_clk`. It stays high for at least the latch-width count. `ser_data` does not change while the latch is high, and it holds for at least the latch-hold count after the latch falls.
- R5: After the latch falls, `in_ready` stays low for at least the latch-hold count plus the gap count.
- R6: A word is taken in the cycle where `in_valid` and `in_ready` are both high, and `busy` is high in the next cycle. `in_ready` is low whenever `busy` is high. A `in_valid` pulse while `in_ready` is low is ignored.
- R7: `done` is high for exactly one cycle per word: the first cycle in which `ser_latch` is low again.
- R8: Out of reset, `in_ready` is 1 and `busy`, `done`, `ser_clk`, `ser_data` and `ser_latch` are 0. All three link outputs are low whenever `busy` is low.
- R9: `busy` is high for exactly WORD_W x (LO + HI) + LSU + LAT + LH + GAP cycles per word. LO is the larger of the phase and setup counts, HI is the larger of the phase and hold counts, and LSU is the larger of the latch-setup and phase counts.
- R10: The cycle counts follow CLK_HZ with upward rounding. At 3.3 MHz, 2000 ns gives 7 cycles and 1000 ns gives 4, so one word keeps `busy` high for 165 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word offered by the client |
| in_word | input | WORD_W | Control word to send |
| in_ready | output | 1 | Block can take a word |
| busy | output | 1 | Transfer in progress, including the closing gap |
| done | output | 1 | One-cycle pulse as the latch returns low |
| ser_clk | output | 1 | Serial clock to the peripheral |
| ser_data | output | 1 | Serial data to the peripheral |
| ser_latch | output | 1 | Latch strobe to the peripheral |

## Verification
A wrong bit counter or a stray shift shows up at the first latch rise as a captured word that is wrong, or as a bit count other than ten. A timer loaded with the wrong interval shows up as a phase, setup or latch measurement below its minimum, within one bit time. It also changes the busy duration, which is checked exactly for every word. A sequencer that leaves the wrong state early or late shows up within one transfer. The signs are a `done` pulse that is missing or misplaced, `ready` rising before the post-latch gap ends, or a link line that is high while the block is idle.

// File: rtl/swt_pkg.sv
package swt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_LAT_SU,
        ST_LAT_HI,
        ST_LAT_HOLD,
        ST_GAP
    } swt_state_e;

    // Round a nanosecond minimum up to whole system clock cycles (at least 1).
    function automatic int unsigned ns_to_cyc(longint unsigned hz, longint unsigned ns);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/swt_interval_timer.sv
module swt_interval_timer #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/swt_shifter.sv
module swt_shifter #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else if (load)
            sh_q <= din;
        else if (shift)
            sh_q <= sh_q << 1;
    end

    assign msb = sh_q[W-1];
endmodule

// File: rtl/swt_sequencer.sv
module swt_sequencer
    import swt_pkg::*;
#(
    parameter int unsigned WORD_W = 10,
    parameter int unsigned CNT_W  = 5,
    parameter int unsigned LO_M1  = 19,
    parameter int unsigned HI_M1  = 19,
    parameter int unsigned LSU_M1 = 19,
    parameter int unsigned LAT_M1 = 19,
    parameter int unsigned LH_M1  = 9,
    parameter int unsigned GAP_M1 = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             sh_load,
    output logic             sh_shift,
    output logic             in_ready,
    output logic             busy,
    output logic             done,
    output logic             ser_clk,
    output logic             ser_latch,
    output logic             data_en
);
    localparam int unsigned BC_W = $clog2(WORD_W + 1);

    swt_state_e      st_q, st_d;
    logic [BC_W-1:0] bits_left_q;
    logic            done_q;

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (st_q)
            ST_IDLE: if (in_valid) begin
                st_d = ST_BIT_LO; tmr_load = 1'b1; tmr_val = CNT_W'(LO_M1); sh_load = 1'b1;
            end
            ST_BIT_LO: if (tmr_expired) begin
                st_d = ST_BIT_HI; tmr_load = 1'b1; tmr_val = CNT_W'(HI_M1);
            end
            ST_BIT_HI: if (tmr_expired) begin
                tmr_load = 1'b1;
                if (bits_left_q != '0) begin
                    st_d = ST_BIT_LO; tmr_val = CNT_W'(LO_M1); sh_shift = 1'b1;
                end else begin
                    st_d = ST_LAT_SU; tmr_val = CNT_W'(LSU_M1);
                end
            end
            ST_LAT_SU: if (tmr_expired) begin
                st_d = ST_LAT_HI; tmr_load = 1'b1; tmr_val = CNT_W'(LAT_M1);
            end
            ST_LAT_HI: if (tmr_expired) begin
                st_d = ST_LAT_HOLD; tmr_load = 1'b1; tmr_val = CNT_W'(LH_M1);
            end
            ST_LAT_HOLD: if (tmr_expired) begin
                st_d = ST_GAP; tmr_load = 1'b1; tmr_val = CNT_W'(GAP_M1);
            end
            ST_GAP: if (tmr_expired) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            bits_left_q <= '0;
            done_q      <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == ST_LAT_HI) && tmr_expired;
            if (sh_load)
                bits_left_q <= BC_W'(WORD_W - 1);
            else if (sh_shift)
                bits_left_q <= bits_left_q - 1'b1;
        end
    end

    assign in_ready  = (st_q == ST_IDLE);
    assign busy      = (st_q != ST_IDLE);
    assign done      = done_q;
    assign ser_clk   = (st_q == ST_BIT_HI);
    assign ser_latch = (st_q == ST_LAT_HI);
    assign data_en   = (st_q != ST_IDLE) && (st_q != ST_GAP);
endmodule

// File: rtl/serial_word_tx.sv
module serial_word_tx
    import swt_pkg::*;
#(
    parameter longint unsigned CLK_HZ      = 10_000_000,
    parameter int unsigned     WORD_W      = 10,
    parameter int unsigned     T_PHASE_NS  = 2000,
    parameter int unsigned     T_SETUP_NS  = 1000,
    parameter int unsigned     T_HOLD_NS   = 1000,
    parameter int unsigned     T_LSU_NS    = 1000,
    parameter int unsigned     T_LAT_NS    = 2000,
    parameter int unsigned     T_LHOLD_NS  = 1000,
    parameter int unsigned     T_GAP_NS    = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic              busy,
    output logic              done,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_latch
);
    localparam int unsigned C_PH  = ns_to_cyc(CLK_HZ, T_PHASE_NS);
    localparam int unsigned C_SU  = ns_to_cyc(CLK_HZ, T_SETUP_NS);
    localparam int unsigned C_HD  = ns_to_cyc(CLK_HZ, T_HOLD_NS);
    localparam int unsigned C_LO  = max_u(C_PH, C_SU);
    localparam int unsigned C_HI  = max_u(C_PH, C_HD);
    localparam int unsigned C_LSU = max_u(C_PH, ns_to_cyc(CLK_HZ, T_LSU_NS));
    localparam int unsigned C_LAT = ns_to_cyc(CLK_HZ, T_LAT_NS);
    localparam int unsigned C_LH  = ns_to_cyc(CLK_HZ, T_LHOLD_NS);
    localparam int unsigned C_GAP = ns_to_cyc(CLK_HZ, T_GAP_NS);
    localparam int unsigned C_MAX = max_u(max_u(max_u(C_LO, C_HI), max_u(C_LSU, C_LAT)),
                                          max_u(C_LH, C_GAP));
    localparam int unsigned CNT_W = $clog2(C_MAX + 1);

    logic             tmr_load, tmr_expired, sh_load, sh_shift, msb, data_en;
    logic [CNT_W-1:0] tmr_val;

    swt_interval_timer #(.W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    swt_shifter #(.W(WORD_W)) shifter_i (
        .clk   (clk),
        .rst   (rst),
        .load  (sh_load),
        .shift (sh_shift),
        .din   (in_word),
        .msb   (msb)
    );

    swt_sequencer #(
        .WORD_W (WORD_W),
        .CNT_W  (CNT_W),
        .LO_M1  (C_LO - 1),
        .HI_M1  (C_HI - 1),
        .LSU_M1 (C_LSU - 1),
        .LAT_M1 (C_LAT - 1),
        .LH_M1  (C_LH - 1),
        .GAP_M1 (C_GAP - 1)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .sh_load     (sh_load),
        .sh_shift    (sh_shift),
        .in_ready    (in_ready),
        .busy        (busy),
        .done        (done),
        .ser_clk     (ser_clk),
        .ser_latch   (ser_latch),
        .data_en     (data_en)
    );

    assign ser_data = data_en & msb;
endmodule

// File: rtl/serial_word_tx_checks.sv
module serial_word_tx_checks #(
    parameter int unsigned PH_MIN  = 20,
    parameter int unsigned LAT_MIN = 20
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic busy,
    input logic done,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_latch
);
    logic [15:0] hi_cnt, lat_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt  <= '0;
            lat_cnt <= '0;
        end else begin
            hi_cnt  <= ser_clk   ? ((hi_cnt  == 16'hFFFF) ? hi_cnt  : hi_cnt  + 1'b1) : '0;
            lat_cnt <= ser_latch ? ((lat_cnt == 16'hFFFF) ? lat_cnt : lat_cnt + 1'b1) : '0;
        end
    end

    assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(ser_clk || ser_data || ser_latch));
    assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> busy);
    assert_ready_low_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_at_fall_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> $fell(ser_latch));
    assert_hold_high_R3: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
    assert_latch_clk_low_R4: assert property (@(posedge clk) disable iff (rst)
        !(ser_clk && ser_latch));
    assert_latch_width_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_latch) |-> (lat_cnt >= 16'(LAT_MIN)));
    assert_clk_high_width_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_clk) |-> (hi_cnt >= 16'(PH_MIN)));
endmodule

bind serial_word_tx serial_word_tx_checks #(
    .PH_MIN  (C_PH),
    .LAT_MIN (C_LAT)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .busy      (busy),
    .done      (done),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_latch (ser_latch)
);

// File: tb/serial_word_tx_tb_top.sv
`timescale 1ns/1ps
module serial_word_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam longint F_MAIN = 10_000_000;
    localparam longint F_ODD  = 3_300_000;
    localparam int WW = 10;

    function automatic int cyc(longint f, longint ns);
        longint c;
        c = (ns * f + 999_999_999) / 1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_PH  = cyc(F_MAIN, 2000);
    localparam int E_SU  = cyc(F_MAIN, 1000);
    localparam int E_HD  = cyc(F_MAIN, 1000);
    localparam int E_LSU = cyc(F_MAIN, 1000);
    localparam int E_LAT = cyc(F_MAIN, 2000);
    localparam int E_LH  = cyc(F_MAIN, 1000);
    localparam int E_GAP = cyc(F_MAIN, 2000);
    localparam int E_TOTAL = WW * (mx(E_PH, E_SU) + mx(E_PH, E_HD))
                           + mx(E_LSU, E_PH) + E_LAT + E_LH + E_GAP;
    localparam int E_ODD = 165;

    logic clk = 1'b0, rst = 1'b1;
    logic valid = 1'b0, v2 = 1'b0;
    logic [WW-1:0] word = '0, w2 = '0;
    logic ready, busy, done, sclk, sdata, slat;
    logic r2, b2, d2, c2, dd2, l2;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_word_tx dut_i (
        .clk(clk), .rst(rst), .in_valid(valid), .in_word(word),
        .in_ready(ready), .busy(busy), .done(done),
        .ser_clk(sclk), .ser_data(sdata), .ser_latch(slat)
    );

    serial_word_tx #(.CLK_HZ(F_ODD)) dut_odd_i (
        .clk(clk), .rst(rst), .in_valid(v2), .in_word(w2),
        .in_ready(r2), .busy(b2), .done(d2),
        .ser_clk(c2), .ser_data(dd2), .ser_latch(l2)
    );

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor state
    int rises, nwords, min_lo, min_hi, min_su, hold_viol, min_lsu, overlap_viol;
    int bitcnt_bad, lat_data_viol, min_lat, done_bad, done_cnt, min_lh, lh_cnt;
    int min_gap, gap_cnt, rb_viol, idle_viol, busy_cyc, busy2_cyc;
    int sclk_run, data_run, lat_run;
    bit lh_on, gap_on, p_sclk, p_sdata, p_lat;
    logic [WW-1:0] cap;
    logic [WW-1:0] words [0:7];

    task automatic clear_stats();
        rises = 0; nwords = 0; min_lo = 1 << 30; min_hi = 1 << 30; min_su = 1 << 30;
        hold_viol = 0; min_lsu = 1 << 30; overlap_viol = 0; bitcnt_bad = 0;
        lat_data_viol = 0; min_lat = 1 << 30; done_bad = 0; done_cnt = 0;
        min_lh = 1 << 30; lh_on = 0; lh_cnt = 0; min_gap = 1 << 30; gap_on = 0;
        gap_cnt = 0; rb_viol = 0; idle_viol = 0; busy_cyc = 0; busy2_cyc = 0;
        cap = '0;
    endtask

    always @(negedge clk) begin
        if (rst) begin
            p_sclk = 0; p_sdata = 0; p_lat = 0; sclk_run = 1; data_run = 1; lat_run = 1;
        end else begin
            if (sclk && !p_sclk) begin
                rises++;
                cap = {cap[WW-2:0], sdata};
                if (rises > 1 && sclk_run < min_lo) min_lo = sclk_run;
                if (data_run < min_su) min_su = data_run;
            end
            if (!sclk && p_sclk && sclk_run < min_hi) min_hi = sclk_run;
            if (sclk && p_sclk && sdata != p_sdata) hold_viol++;
            if (slat && !p_lat) begin
                if (sclk_run < min_lsu) min_lsu = sclk_run;
                if (nwords < 8) words[nwords] = cap;
                if (rises != WW) bitcnt_bad++;
                nwords++;
                rises = 0;
            end
            if (slat && sclk) overlap_viol++;
            if (slat && p_lat && sdata != p_sdata) lat_data_viol++;
            if (lh_on) begin
                if (sdata != p_sdata) begin
                    if (lh_cnt < min_lh) min_lh = lh_cnt;
                    lh_on = 0;
                end else lh_cnt++;
            end
            if (gap_on) begin
                if (!busy) begin
                    if (gap_cnt < min_gap) min_gap = gap_cnt;
                    gap_on = 0;
                end else gap_cnt++;
            end
            if (!slat && p_lat) begin
                if (lat_run < min_lat) min_lat = lat_run;
                if (!done) done_bad++;
                lh_on = 1; lh_cnt = 1; gap_on = 1; gap_cnt = 1;
            end else if (done) done_bad++;
            if (done) done_cnt++;
            if (ready == busy) rb_viol++;
            if (!busy && (sclk || sdata || slat)) idle_viol++;
            if (busy) busy_cyc++;
            if (b2) busy2_cyc++;
            sclk_run = (sclk == p_sclk) ? sclk_run + 1 : 1;
            data_run = (sdata == p_sdata) ? data_run + 1 : 1;
            lat_run  = (slat == p_lat) ? lat_run + 1 : 1;
            p_sclk = sclk; p_sdata = sdata; p_lat = slat;
        end
    end

    task automatic offer(input logic [WW-1:0] w);
        @(negedge clk);
        valid = 1'b1; word = w;
        while (!ready) @(negedge clk);
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_timing(input string tag);
        check(bitcnt_bad == 0, "R1 bit count", bitcnt_bad, 0);
        check(min_lo >= E_PH, "R2 clock low phase", min_lo, E_PH);
        check(min_hi >= E_PH, "R2 clock high phase", min_hi, E_PH);
        check(min_su >= E_SU, "R3 data setup", min_su, E_SU);
        check(hold_viol == 0, "R3 data change while clock high", hold_viol, 0);
        check(min_lsu >= E_LSU && min_lsu >= E_PH, "R4 latch setup", min_lsu, E_LSU);
        check(overlap_viol == 0, "R4 latch with clock high", overlap_viol, 0);
        check(min_lat >= E_LAT, "R4 latch width", min_lat, E_LAT);
        check(lat_data_viol == 0, "R4 data change under latch", lat_data_viol, 0);
        check(min_lh >= E_LH, "R4 data hold after latch", min_lh, E_LH);
        check(min_gap >= E_LH + E_GAP, "R5 post-latch gap", min_gap, E_LH + E_GAP);
        check(done_bad == 0, "R7 done placement", done_bad, 0);
        check(rb_viol == 0, "R6 ready vs busy", rb_viol, 0);
        check(idle_viol == 0, "R8 idle lines low", idle_viol, 0);
        if (tag.len() == 0) $display("timing checked");
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(ready == 1'b1, "R8 reset ready", int'(ready), 1);
        check(busy == 1'b0 && done == 1'b0, "R8 reset busy/done", int'({busy, done}), 0);
        check({sclk, sdata, slat} == 3'b000, "R8 reset lines", int'({sclk, sdata, slat}), 0);
    endtask

    task automatic t_word(input logic [WW-1:0] w);
        @(posedge clk); clear_stats();
        offer(w);
        wait_idle();
        check(nwords == 1, "R1 word count", nwords, 1);
        check(words[0] == w, "R1 captured word msb first", int'(words[0]), int'(w));
        check(done_cnt == 1, "R7 done pulses", done_cnt, 1);
        check(busy_cyc == E_TOTAL, "R9 transfer length", busy_cyc, E_TOTAL);
        check_timing("word");
    endtask

    task automatic t_ignore();
        @(posedge clk); clear_stats();
        offer(10'h155);
        repeat (50) @(negedge clk);
        valid = 1'b1; word = 10'h0AA;
        @(negedge clk);
        valid = 1'b0;
        wait_idle();
        repeat (100) @(negedge clk);
        check(nwords == 1, "R6 ignored request word count", nwords, 1);
        check(words[0] == 10'h155, "R6 word unchanged by ignored request", int'(words[0]), 'h155);
        check(busy_cyc == E_TOTAL, "R6 no second transfer", busy_cyc, E_TOTAL);
    endtask

    task automatic t_back_to_back();
        @(posedge clk); clear_stats();
        offer(10'h2C3);
        valid = 1'b1; word = 10'h13C;
        while (!ready) @(negedge clk);
        @(negedge clk);
        valid = 1'b0;
        wait_idle();
        check(nwords == 2, "R5 back-to-back word count", nwords, 2);
        check(words[0] == 10'h2C3, "R1 first word", int'(words[0]), 'h2C3);
        check(words[1] == 10'h13C, "R1 second word", int'(words[1]), 'h13C);
        check(done_cnt == 2, "R7 two done pulses", done_cnt, 2);
        check(busy_cyc == 2 * E_TOTAL, "R9 two transfers", busy_cyc, 2 * E_TOTAL);
        check_timing("b2b");
    endtask

    task automatic t_odd_clock();
        @(posedge clk); clear_stats();
        @(negedge clk);
        v2 = 1'b1; w2 = 10'h2F1;
        @(negedge clk);
        v2 = 1'b0;
        while (b2) @(negedge clk);
        repeat (3) @(negedge clk);
        check(busy2_cyc == E_ODD, "R10 rounded-up cycles at 3.3 MHz", busy2_cyc, E_ODD);
        check(r2 == 1'b1 && {c2, dd2, l2} == 3'b000, "R10 idle after odd transfer",
              int'({r2, c2, dd2, l2}), 8);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        clear_stats();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_word(10'h2A5);
        t_word(10'h3FF);
        t_word(10'h001);
        t_word(10'h200);
        t_ignore();
        t_back_to_back();
        t_odd_clock();
        finish_run();
    end

    initial begin
        repeat (150_000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150_000, 0);
        finish_run();
    end
endmodule